// File: doc/BRIEF.md
# Self-Paced Handshake Serial Word Sender

This block is the host end of a three-wire serial link to a small display unit. A caller hands it a 16-bit word. The block sends the word as two bytes, one bit at a time. It drives a clock line and a data line, and it watches an acknowledge line driven back by the device. The link has no fixed bit rate. Every bit is paced by the device. The host pulls the clock low and waits for the acknowledge to drop. It then places the bit and holds it for a programmable number of system clocks before raising the clock. Finally it waits for the acknowledge to rise again before starting the next bit.

The acknowledge level seen when the clock rises is shifted into a byte-wide read-back register. A correct device always answers with a low level there, so each byte reads back as zero. A nonzero byte is reported as an error. Either wait can stall because the device stops responding. In that case a timeout abandons the transfer, returns the clock to its high idle level and reports an error. The caller therefore never blocks. It pulses start, watches busy, and takes the result from a single-cycle done pulse that carries an error flag.

Top module: `ack_link_tx`

## Requirements
- R1: After reset, and whenever no transfer is running, the link clock output is high and busy is low. A reset in the middle of a transfer returns the block to this state on the next clock.
- R2: A start pulse while idle is accepted: on the next clock busy is high and the link clock is low. A start pulse while busy has no effect on the word being sent, and no second transfer follows.
- R3: After pulling the link clock low, the block waits for the acknowledge input to read low through a SYNC_STAGES-flop synchronizer. The data output changes only on the clock after a low acknowledge was seen.
- R4: The link clock rises exactly SETUP_CYC clocks after the data output is updated. That is SYNC_STAGES+1+SETUP_CYC clocks after the acknowledge pin falls. The data output is stable while the link clock is high.
- R5: The link clock falls for the next bit only after the synchronized acknowledge has been seen high. This happens SYNC_STAGES+1 clocks after the acknowledge pin rises.
- R6: A transfer carries exactly 16 bits, most significant bit first, so data bits 15..8 form the first byte.
- R7: The synchronized acknowledge level at each link clock rise is shifted into a read-back byte. If a completed byte reads back other than 0x00, the done pulse carries error = 1. Otherwise it carries error = 0.
- R8: If the acknowledge does not reach the awaited level within TIMEOUT_CYC clocks of the wait starting, the transfer is abandoned. Done with error = 1 is raised TIMEOUT_CYC clocks after the wait began, and the clock returns high. A later transfer works normally.
- R9: Done is a one-cycle pulse. Busy falls on the same clock. The error output is high only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to send data_i (honoured only while idle) |
| data_i | input | 16 | Word to send; bits 15..8 go first |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| err_o | output | 1 | Error flag, valid with done_o |
| lnk_clk_o | output | 1 | Link clock to the device, idle high |
| lnk_dat_o | output | 1 | Link data to the device |
| lnk_ack_i | input | 1 | Acknowledge from the device, asynchronous |

## Verification
On every cycle, the assertions check the following:
- the idle-high clock;
- that the data line changes only after a synchronized low acknowledge and never while the clock is high;
- that every later falling clock edge follows a high acknowledge;
- the single-cycle done pulse and its relation to busy and the error flag.

Other behaviour needs the bench's device model and its scenarios. These are the exact setup and turnaround latencies, the bit order and count of a whole word, the read-back error from a device that releases its acknowledge too early, and the exact timeout instant for a stalled low-wait and a stalled high-wait. They also include recovery after a timeout, an ignored start while busy, and a reset mid-transfer.

// File: rtl/ack_link_pkg.sv
package ack_link_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACK_LO = 2'd1,
    ST_SETUP  = 2'd2,
    ST_ACK_HI = 2'd3
  } lnk_state_t;
endpackage

// File: rtl/ack_link_sync.sv
module ack_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= 1'b1;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ack_link_timer.sv
module ack_link_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == LAST);
endmodule

// File: rtl/ack_link_rx.sv
module ack_link_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (shift) q <= {q[W-2:0], sin};
  end
endmodule

// File: rtl/ack_link_tx.sv
module ack_link_tx
  import ack_link_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int SETUP_CYC   = 3,
  parameter int TIMEOUT_CYC = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              lnk_clk_o,
  output logic              lnk_dat_o,
  input  logic              lnk_ack_i
);
  localparam int BC_W = $clog2(WORD_W);
  localparam int BP_W = $clog2(BYTE_W);
  localparam int SC_W = $clog2(SETUP_CYC + 1);
  localparam logic [BC_W-1:0] WORD_LAST  = BC_W'(WORD_W - 1);
  localparam logic [BP_W-1:0] BYTE_LAST  = BP_W'(BYTE_W - 1);
  localparam logic [SC_W-1:0] SETUP_LAST = SC_W'(SETUP_CYC - 1);

  lnk_state_t        state_q;
  logic              ack_s;
  logic              tmr_clr, tmr_hit;
  logic [WORD_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_q;
  logic [BC_W-1:0]   bit_cnt;
  logic [BP_W-1:0]   byte_pos;
  logic [SC_W-1:0]   setup_cnt;
  logic              err_acc;
  logic              take_start, ack_low_seen, setup_end, ack_high_seen;
  logic              byte_end, byte_bad;

  ack_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(lnk_ack_i), .q(ack_s)
  );

  assign take_start    = (state_q == ST_IDLE) && start_i;
  assign ack_low_seen  = (state_q == ST_ACK_LO) && !ack_s;
  assign setup_end     = (state_q == ST_SETUP) && (setup_cnt == SETUP_LAST);
  assign ack_high_seen = (state_q == ST_ACK_HI) && ack_s;
  assign byte_end      = (byte_pos == BYTE_LAST);
  assign byte_bad      = byte_end && (rx_q != '0);

  // the wait timer restarts on every wait entry and every handshake advance
  assign tmr_clr = !((state_q == ST_ACK_LO) || (state_q == ST_ACK_HI))
                   || ack_low_seen || ack_high_seen;

  ack_link_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .clr(tmr_clr), .hit(tmr_hit)
  );

  ack_link_rx #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst),
    .clr(take_start || (ack_high_seen && byte_end)),
    .shift(setup_end), .sin(ack_s), .q(rx_q)
  );

  always_ff @(posedge clk) begin
    if (rst)             tx_q <= '0;
    else if (take_start) tx_q <= data_i;
    else if (ack_low_seen) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    done_o <= 1'b0;
    err_o  <= 1'b0;
    if (rst) begin
      state_q   <= ST_IDLE;
      busy_o    <= 1'b0;
      lnk_clk_o <= 1'b1;
      lnk_dat_o <= 1'b0;
      bit_cnt   <= '0;
      byte_pos  <= '0;
      setup_cnt <= '0;
      err_acc   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_ACK_LO;
            busy_o    <= 1'b1;
            lnk_clk_o <= 1'b0;
            bit_cnt   <= '0;
            byte_pos  <= '0;
            err_acc   <= 1'b0;
          end
        end
        ST_ACK_LO: begin
          if (!ack_s) begin
            lnk_dat_o <= tx_q[WORD_W-1];
            setup_cnt <= '0;
            state_q   <= ST_SETUP;
          end else if (tmr_hit) begin
            state_q   <= ST_IDLE;
            busy_o    <= 1'b0;
            lnk_clk_o <= 1'b1;
            done_o    <= 1'b1;
            err_o     <= 1'b1;
          end
        end
        ST_SETUP: begin
          if (setup_cnt == SETUP_LAST) begin
            lnk_clk_o <= 1'b1;
            state_q   <= ST_ACK_HI;
          end else begin
            setup_cnt <= setup_cnt + 1'b1;
          end
        end
        ST_ACK_HI: begin
          if (ack_s) begin
            if (byte_bad) err_acc <= 1'b1;
            byte_pos <= byte_end ? '0 : byte_pos + 1'b1;
            if (bit_cnt == WORD_LAST) begin
              state_q <= ST_IDLE;
              busy_o  <= 1'b0;
              done_o  <= 1'b1;
              err_o   <= err_acc || byte_bad;
            end else begin
              bit_cnt   <= bit_cnt + 1'b1;
              lnk_clk_o <= 1'b0;
              state_q   <= ST_ACK_LO;
            end
          end else if (tmr_hit) begin
            state_q <= ST_IDLE;
            busy_o  <= 1'b0;
            done_o  <= 1'b1;
            err_o   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ack_link_tx_chk.sv
module ack_link_tx_chk (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic lnk_clk_o,
  input logic lnk_dat_o,
  input logic ack_s
);
  // R1: the link clock is high whenever no transfer runs
  p_idle_clk_high_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> lnk_clk_o);

  // R3: data changes only after a synchronized low acknowledge
  p_dat_after_ack_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(lnk_dat_o) && !$past(rst) |-> !lnk_clk_o && !$past(ack_s));

  // R4: data held while the link clock is high
  p_dat_hold_r4: assert property (@(posedge clk) disable iff (rst)
    lnk_clk_o && $past(lnk_clk_o) |-> $stable(lnk_dat_o));

  // R5: a later bit starts only after a high acknowledge
  p_fall_after_ack_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(lnk_clk_o) && $past(busy_o) |-> $past(ack_s));

  // R9: done lasts one cycle, closes busy, and carries the error flag
  p_done_one_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && $past(busy_o));
  p_err_done_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |-> done_o);
endmodule

bind ack_link_tx ack_link_tx_chk u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .lnk_clk_o(lnk_clk_o), .lnk_dat_o(lnk_dat_o), .ack_s(ack_s)
);

// File: tb/ack_link_tx_test.sv
module ack_link_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP = 3;
  localparam int SYNC  = 2;
  localparam int TMO   = 64;
  localparam int LAT   = SYNC + 1 + SETUP;
  localparam int GAP   = SYNC + 1;
  localparam int MD_OK = 0, MD_EARLY = 1, MD_STUCK = 2, MD_HANG = 3;

  localparam int NV = 6;
  localparam logic [15:0] V_DATA [NV] = '{16'hA55A, 16'hFF00, 16'h0001, 16'h8000, 16'h1234, 16'hBEEF};
  localparam int          V_DLY  [NV] = '{0, 3, 1, 2, 0, 5};
  localparam int          V_MODE [NV] = '{MD_OK, MD_OK, MD_OK, MD_EARLY, MD_EARLY, MD_OK};
  localparam int          V_FLT  [NV] = '{0, 0, 0, 3, 12, 0};
  localparam logic        V_ERR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0, rst = 1'b1, start_i = 1'b0;
  logic [15:0] data_i = '0;
  logic busy_o, done_o, err_o, lnk_clk_o, lnk_dat_o;
  logic lnk_ack_i;

  int checks = 0, errors = 0, n_done = 0;
  int m_dly = 0, m_mode = MD_OK, m_flt = 0, m_bit = 0, m_lat = -1, m_gap = -1;
  logic [15:0] m_cap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ack_link_tx #(.SETUP_CYC(SETUP), .TIMEOUT_CYC(TMO), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .lnk_clk_o(lnk_clk_o), .lnk_dat_o(lnk_dat_o), .lnk_ack_i(lnk_ack_i)
  );

  always @(negedge clk) if (done_o === 1'b1) n_done++;

  // device model
  initial begin
    int t, g;
    lnk_ack_i = 1'b1;
    forever begin
      @(negedge clk);
      if (rst || lnk_clk_o !== 1'b0) continue;
      repeat (m_dly) @(negedge clk);
      if (m_mode == MD_STUCK && m_bit == m_flt) begin
        while (busy_o === 1'b1) @(negedge clk);
        continue;
      end
      lnk_ack_i = 1'b0;
      if (m_mode == MD_EARLY && m_bit == m_flt) begin
        @(negedge clk);
        lnk_ack_i = 1'b1;
      end
      t = 0;
      while (lnk_clk_o === 1'b0 && busy_o === 1'b1) begin @(negedge clk); t++; end
      if (busy_o !== 1'b1) begin lnk_ack_i = 1'b1; continue; end
      if (m_bit == 0) m_lat = t;
      m_cap = {m_cap[14:0], lnk_dat_o};
      m_bit++;
      if (m_mode == MD_HANG && m_bit - 1 == m_flt) begin
        while (busy_o === 1'b1) @(negedge clk);
        lnk_ack_i = 1'b1;
        continue;
      end
      if (lnk_ack_i == 1'b0) begin
        repeat (m_dly) @(negedge clk);
        lnk_ack_i = 1'b1;
      end
      g = 0;
      while (lnk_clk_o === 1'b1 && busy_o === 1'b1) begin @(negedge clk); g++; end
      if (m_bit == 1 && lnk_clk_o === 1'b0) m_gap = g;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [15:0] d, output logic e, output int cyc);
    m_cap = '0; m_bit = 0; m_lat = -1; m_gap = -1;
    @(negedge clk); start_i = 1'b1; data_i = d;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o === 1'b1 && lnk_clk_o === 1'b0, "R2", "start accepted {busy,clk}",
        {busy_o, lnk_clk_o}, 2'b10);
    cyc = 0;
    while (done_o !== 1'b1) begin @(negedge clk); cyc++; end
    e = err_o;
    @(negedge clk);
    chk(done_o === 1'b0, "R9", "done pulse width", done_o, 0);
    chk(busy_o === 1'b0 && lnk_clk_o === 1'b1, "R1", "idle after done {busy,clk}",
        {busy_o, lnk_clk_o}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic e;
    int cyc, nd;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && lnk_clk_o === 1'b1 && done_o === 1'b0, "R1",
        "reset state {busy,clk,done}", {busy_o, lnk_clk_o, done_o}, 3'b010);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      m_dly = V_DLY[i]; m_mode = V_MODE[i]; m_flt = V_FLT[i];
      run_xfer(V_DATA[i], e, cyc);
      chk(e === V_ERR[i], "R7", "read-back error flag", e, V_ERR[i]);
      chk(m_cap === V_DATA[i], "R6", "bits captured MSB first", m_cap, V_DATA[i]);
      chk(m_bit == 16, "R6", "bit count", m_bit, 16);
      if (V_MODE[i] == MD_OK) begin
        chk(m_lat == LAT, "R4", "ack fall to clock rise", m_lat, LAT);
        chk(m_gap == GAP, "R5", "ack rise to clock fall", m_gap, GAP);
      end
      repeat (3) @(negedge clk);
    end

    // R8: device never answers the first bit
    m_dly = 0; m_mode = MD_STUCK; m_flt = 0;
    run_xfer(16'h7E81, e, cyc);
    chk(e === 1'b1, "R8", "low-wait timeout error", e, 1);
    chk(cyc == TMO, "R8", "low-wait timeout instant", cyc, TMO);

    // R8: device never releases its acknowledge on bit 9
    m_dly = 1; m_mode = MD_HANG; m_flt = 9;
    run_xfer(16'h3C3C, e, cyc);
    chk(e === 1'b1, "R8", "high-wait timeout error", e, 1);
    chk(m_bit == 10, "R8", "bits before hang", m_bit, 10);

    // R8: recovery after timeouts
    m_dly = 1; m_mode = MD_OK;
    run_xfer(16'h5AA5, e, cyc);
    chk(e === 1'b0, "R8", "recovery error flag", e, 0);
    chk(m_cap === 16'h5AA5, "R8", "recovery data", m_cap, 16'h5AA5);

    // R2: start while busy is ignored
    m_dly = 2; m_mode = MD_OK;
    m_cap = '0; m_bit = 0; nd = n_done;
    @(negedge clk); start_i = 1'b1; data_i = 16'hC3A5;
    @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    start_i = 1'b1; data_i = 16'h0000;
    @(negedge clk); start_i = 1'b0;
    while (busy_o === 1'b1) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(m_cap === 16'hC3A5, "R2", "word unchanged by late start", m_cap, 16'hC3A5);
    chk(n_done - nd == 1, "R2", "done pulses", n_done - nd, 1);
    chk(busy_o === 1'b0, "R2", "no second transfer", busy_o, 0);

    // R1: reset in the middle of a transfer
    m_cap = '0; m_bit = 0;
    @(negedge clk); start_i = 1'b1; data_i = 16'hFFFF;
    @(negedge clk); start_i = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0 && lnk_clk_o === 1'b1, "R1", "mid-transfer reset {busy,clk}",
        {busy_o, lnk_clk_o}, 2'b01);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule